// File: doc/BRIEF.md
# Partial-Word Store Byte Lane Unit

This block turns a "store bytes" request into one aligned, masked write beat on a big-endian word-wide memory port. A request carries a byte address, a register value and a fill mode. In begin mode the store covers the addressed byte through the last byte of the word. In end mode it covers the first byte of the word up to, but not including, the addressed byte. The low address bits alone decide which lanes are written.

Each request yields exactly one registered write beat: an aligned word address, a byte-enable mask and lane-aligned write data. A three-byte store is therefore never split, so it is indivisible at the port. In end mode an aligned address writes nothing. It still raises a probe flag, so that the memory side can run its permission check and mark the line dirty. Address translation, protection and caching sit outside this block.

Top module: `sbl_store_lanes`

## Requirements
- R1: While reset is asserted and in the first cycle after it, wr_valid_o, wr_mask_o, wr_data_o and probe_o are all zero.
- R2: A request sampled high on a rising edge makes wr_valid_o high for the following cycle. A cycle with no request makes wr_valid_o low in the following cycle. Back-to-back requests give back-to-back beats.
- R3: wr_addr_o equals the request address with its two low bits cleared.
- R4: In begin mode (mode_i = 0), with address offset o, the mask enables lanes o through 3. Mask bit k enables lane k, and lane 0 is the most significant byte (bits 31:24). Offset 0 therefore gives 4'b1111, and offset 3 gives 4'b1000.
- R5: In end mode (mode_i = 1), with address offset o of 1 to 3, the mask enables lanes 0 through o-1: 4'b0001, 4'b0011 and 4'b0111.
- R6: In end mode at offset 0, the mask is 4'b0000 and probe_o is 1. In every other case probe_o is 0 and the mask is nonzero.
- R7: Each enabled lane k carries value bits [31-8k -: 8] unshifted. Every disabled lane carries zero. Applying the beats to a byte memory gives the same contents as storing the selected bytes one by one.
- R8: Every nonzero mask is one contiguous run of lanes that touches lane 0 or lane 3, issued in a single beat.
- R9: In a cycle with no request, wr_addr_o, wr_mask_o, wr_data_o and probe_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Store request strobe |
| mode_i | input | 1 | Fill mode: 0 begin, 1 end |
| addr_i | input | ADDR_W | Byte address of the request |
| value_i | input | 8*BYTES | Register value to store |
| wr_valid_o | output | 1 | One-cycle write beat valid |
| wr_addr_o | output | ADDR_W | Aligned word address |
| wr_mask_o | output | BYTES | Byte enables, bit k is lane k |
| wr_data_o | output | 8*BYTES | Lane-aligned write data, disabled lanes zero |
| probe_o | output | 1 | Zero-byte store that still needs a permission probe |

## Verification
A wrong offset decode appears one cycle after the request, as a mask with lanes missing or extra lanes set, or as a probe on a store that writes bytes. A fault in the output register state shows up in two ways: a beat that lingers past its cycle or is missing, or fields that drift while the port is idle. Both are visible on the cycle right after the faulty edge. Comparing a byte memory written from the beats with one written byte by byte catches lane and data misplacement, even where each field looks plausible on its own.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
    typedef enum logic {
        FILL_BEGIN = 1'b0,
        FILL_END   = 1'b1
    } fill_mode_e;
endpackage

// File: rtl/sbl_lane_mask.sv
module sbl_lane_mask
    import sbl_pkg::*;
#(
    parameter int BYTES = 4,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic [OFF_W-1:0] off_i,
    input  fill_mode_e       mode_i,
    output logic [BYTES-1:0] mask_o,
    output logic             probe_o
);
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE = OFF_W'(i);
        always_comb begin
            if (mode_i == FILL_BEGIN) mask_o[i] = (LANE >= off_i);
            else                      mask_o[i] = (LANE < off_i);
        end
    end

    always_comb probe_o = (mode_i == FILL_END) && (off_i == '0);
endmodule

// File: rtl/sbl_lane_data.sv
module sbl_lane_data #(
    parameter int BYTES  = 4,
    parameter int BYTE_W = 8,
    localparam int DATA_W = BYTES * BYTE_W
) (
    input  logic [DATA_W-1:0] value_i,
    input  logic [BYTES-1:0]  mask_i,
    output logic [DATA_W-1:0] data_o
);
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        localparam int HI = DATA_W - 1 - i * BYTE_W;
        always_comb data_o[HI -: BYTE_W] = mask_i[i] ? value_i[HI -: BYTE_W] : '0;
    end
endmodule

// File: rtl/sbl_store_lanes.sv
module sbl_store_lanes
    import sbl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BYTES  = 4,
    localparam int BYTE_W = 8,
    localparam int DATA_W = BYTES * BYTE_W,
    localparam int OFF_W  = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] value_i,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTES-1:0]  wr_mask_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              probe_o
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [BYTES-1:0]  mask;
        logic [DATA_W-1:0] data;
        logic              probe;
    } beat_t;

    beat_t             beat_d, beat_q;
    logic [BYTES-1:0]  mask_c;
    logic [DATA_W-1:0] data_c;
    logic              probe_c;
    fill_mode_e        mode_c;

    assign mode_c = fill_mode_e'(mode_i);

    sbl_lane_mask #(.BYTES(BYTES)) u_mask (
        .off_i   (addr_i[OFF_W-1:0]),
        .mode_i  (mode_c),
        .mask_o  (mask_c),
        .probe_o (probe_c)
    );

    sbl_lane_data #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_data (
        .value_i (value_i),
        .mask_i  (mask_c),
        .data_o  (data_c)
    );

    always_comb begin
        beat_d       = beat_q;
        beat_d.valid = req_i;
        if (req_i) begin
            beat_d.addr  = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            beat_d.mask  = mask_c;
            beat_d.data  = data_c;
            beat_d.probe = probe_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beat_q <= '0;
        else        beat_q <= beat_d;
    end

    assign wr_valid_o = beat_q.valid;
    assign wr_addr_o  = beat_q.addr;
    assign wr_mask_o  = beat_q.mask;
    assign wr_data_o  = beat_q.data;
    assign probe_o    = beat_q.probe;

    p_req_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> wr_valid_o);
    p_idle_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !wr_valid_o);
    p_probe_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && probe_o) |-> (wr_mask_o == '0));
    p_store_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !probe_o) |-> (wr_mask_o != '0));
    p_edge_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !probe_o) |-> (wr_mask_o[0] || wr_mask_o[BYTES-1]));
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(wr_mask_o) && $stable(wr_data_o) && $stable(wr_addr_o) && $stable(probe_o)));
endmodule

// File: tb/sim_sbl_store_lanes.sv
module sim_sbl_store_lanes;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [31:0] value_i = '0;
    logic        wr_valid_o;
    logic [31:0] wr_addr_o;
    logic [3:0]  wr_mask_o;
    logic [31:0] wr_data_o;
    logic        probe_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] dut_mem [64];
    logic [7:0] ref_mem [64];

    always #2 clk = ~clk;

    sbl_store_lanes u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode_i),
        .addr_i(addr_i), .value_i(value_i), .wr_valid_o(wr_valid_o),
        .wr_addr_o(wr_addr_o), .wr_mask_o(wr_mask_o), .wr_data_o(wr_data_o),
        .probe_o(probe_o)
    );

    typedef struct packed {
        logic        mode;
        logic [31:0] addr;
        logic [31:0] value;
        logic [31:0] e_addr;
        logic [3:0]  e_mask;
        logic [31:0] e_data;
        logic        e_probe;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 32'h100, 32'hA1B2C3D4, 32'h100, 4'b1111, 32'hA1B2C3D4, 1'b0},
        '{1'b0, 32'h105, 32'h11223344, 32'h104, 4'b1110, 32'h00223344, 1'b0},
        '{1'b0, 32'h10A, 32'h55667788, 32'h108, 4'b1100, 32'h00007788, 1'b0},
        '{1'b0, 32'h10F, 32'h99AABBCC, 32'h10C, 4'b1000, 32'h000000CC, 1'b0},
        '{1'b1, 32'h110, 32'hDEADBEEF, 32'h110, 4'b0000, 32'h00000000, 1'b1},
        '{1'b1, 32'h115, 32'hCAFEF00D, 32'h114, 4'b0001, 32'hCA000000, 1'b0},
        '{1'b1, 32'h11A, 32'h01234567, 32'h118, 4'b0011, 32'h01230000, 1'b0},
        '{1'b1, 32'h11F, 32'h89ABCDEF, 32'h11C, 4'b0111, 32'h89ABCD00, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Byte-by-byte reference store into the model memory.
    task automatic ref_store(input logic mode, input logic [31:0] addr, input logic [31:0] val);
        int off = int'(addr[1:0]);
        int base = int'(addr[5:0]) - off;
        for (int k = 0; k < 4; k++) begin
            if ((mode == 1'b0 && k >= off) || (mode == 1'b1 && k < off))
                ref_mem[base + k] = val[31 - 8*k -: 8];
        end
    endtask

    task automatic apply_beat();
        if (wr_valid_o)
            for (int k = 0; k < 4; k++)
                if (wr_mask_o[k]) dut_mem[int'(wr_addr_o[5:0]) + k] = wr_data_o[31 - 8*k -: 8];
    endtask

    task automatic check_vec(input vec_t v, input string tag);
        chk({tag, " R2 valid"}, 32'(wr_valid_o), 32'd1);
        chk({tag, " R3 addr"}, wr_addr_o, v.e_addr);
        chk({tag, v.mode ? " R5 mask" : " R4 mask"}, 32'(wr_mask_o), 32'(v.e_mask));
        chk({tag, " R7 data"}, wr_data_o, v.e_data);
        chk({tag, " R6 probe"}, 32'(probe_o), 32'(v.e_probe));
        chk({tag, " R8 single beat edge run"},
            32'(v.e_probe || wr_mask_o[0] || wr_mask_o[3]), 32'd1);
    endtask

    task automatic drive(input vec_t v);
        req_i = 1'b1; mode_i = v.mode; addr_i = v.addr; value_i = v.value;
        ref_store(v.mode, v.addr, v.value);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin dut_mem[i] = 8'h00; ref_mem[i] = 8'h00; end
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(wr_valid_o), 32'd0);
        chk("R1 reset mask", 32'(wr_mask_o), 32'd0);
        chk("R1 reset data", wr_data_o, 32'd0);
        chk("R1 reset probe", 32'(probe_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release valid", 32'(wr_valid_o), 32'd0);

        // Table walk: one request, then one idle cycle.
        for (int i = 0; i < 8; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            req_i = 1'b0;
            check_vec(VECS[i], $sformatf("vec%0d", i));
            apply_beat();
            @(negedge clk);
            chk($sformatf("vec%0d R2 pulse ends", i), 32'(wr_valid_o), 32'd0);
            chk($sformatf("vec%0d R9 hold mask", i), 32'(wr_mask_o), 32'(VECS[i].e_mask));
            chk($sformatf("vec%0d R9 hold data", i), wr_data_o, VECS[i].e_data);
        end

        // Idle with changing inputs: outputs must stay put.
        mode_i = 1'b0; addr_i = 32'h123; value_i = 32'hFFFFFFFF;
        repeat (2) @(negedge clk);
        chk("R9 idle addr", wr_addr_o, 32'h11C);
        chk("R9 idle probe", 32'(probe_o), 32'd0);

        // Back-to-back requests: end offset 0 probe then begin offset 1.
        drive(VECS[4]);
        @(negedge clk);
        drive(VECS[1]);
        check_vec(VECS[4], "b2b first");
        apply_beat();
        @(negedge clk);
        req_i = 1'b0;
        check_vec(VECS[1], "b2b second");
        apply_beat();
        @(negedge clk);
        chk("R2 b2b pulse ends", 32'(wr_valid_o), 32'd0);

        // Overwrite stores at the same word in both modes.
        drive('{1'b0, 32'h122, 32'hAAAABBBB, 32'h120, 4'b1100, 32'h0000BBBB, 1'b0});
        @(negedge clk);
        drive('{1'b1, 32'h123, 32'h12345678, 32'h120, 4'b0111, 32'h12345600, 1'b0});
        check_vec('{1'b0, 32'h122, 32'hAAAABBBB, 32'h120, 4'b1100, 32'h0000BBBB, 1'b0}, "ovl begin");
        apply_beat();
        @(negedge clk);
        req_i = 1'b0;
        check_vec('{1'b1, 32'h123, 32'h12345678, 32'h120, 4'b0111, 32'h12345600, 1'b0}, "ovl end");
        apply_beat();
        @(negedge clk);

        for (int w = 0; w < 16; w++)
            chk($sformatf("R7 memory word %0d", w),
                {dut_mem[4*w], dut_mem[4*w+1], dut_mem[4*w+2], dut_mem[4*w+3]},
                {ref_mem[4*w], ref_mem[4*w+1], ref_mem[4*w+2], ref_mem[4*w+3]});

        // Reset while a beat is present.
        drive(VECS[0]);
        @(negedge clk);
        req_i = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1 mid reset valid", 32'(wr_valid_o), 32'd0);
        chk("R1 mid reset mask", 32'(wr_mask_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule